// File: doc/BRIEF.md
# Variable-Width Serial Command Decoder

This block is the slave-side front end of a select-framed link whose data lines may run 1, 2, 4 or 8 bits wide. While the active-low select is high, the block idles. On the first rising clock edge that finds the select low, it samples all eight data lines as one command byte. From that byte it takes a 4-bit command code and the transfer width the master asks for. The width is chosen by three flag lines with a fixed priority. Lines the master leaves undriven read high, so a master that uses only one line still selects a valid width.

Every later edge inside the same frame shifts in as many bits as the chosen width, taken from the lowest data lines, least significant bits first. When eight bits have been gathered, the block presents the byte together with a one-cycle valid strobe. The command and width stay on the outputs for the whole frame. Raising the select at any point ends the frame and drops any partial byte. The next frame starts again with a command byte.

Top module: `cmdWidthSlave`

## Requirements
- R1: While `rstN` is low, and directly after reset, `active` and `byteValid` are 0.
- R2: The first rising edge with `selN` low and no frame open is the command edge. After that edge `active` is 1 and `cmdCode` = {dataIn[0], dataIn[3], dataIn[5], dataIn[6]} (MSB first). Line 7 plays no part.
- R3: At the command edge `busWidth` is decoded as follows: 3 (8 bits) if dataIn[4] is 0; otherwise 2 (4 bits) if dataIn[2] is 0; otherwise 1 (2 bits) if dataIn[1] is 0; otherwise 0 (1 bit). A higher flag wins over any lower flag that is also low.
- R4: A command byte with all lines high, which is what undriven lines with pull-ups give, selects `busWidth` 0 (1 bit).
- R5: Each edge after the command edge in the same frame shifts in w bits from dataIn[w-1:0]. The first chunk lands in the least significant bits. A byte takes 8/w edges.
- R6: After the edge that completes a byte, `byteOut` holds that byte and `byteValid` is 1 for exactly that cycle. After every other data edge `byteValid` is 0.
- R7: In data beats, lines at or above the chosen width have no effect on `byteOut`.
- R8: After an edge that finds `selN` high, `active` and `byteValid` are 0 and any partial byte is discarded. The next frame begins with a fresh command edge and a fresh byte count.
- R9: `busWidth` and `cmdCode` do not change between the command edge and the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Frame select, active low |
| dataIn | input | 8 | Data lines, read as 1 when undriven |
| active | output | 1 | A frame is open and its command has been taken |
| busWidth | output | 2 | Width code: 0=1, 1=2, 2=4, 3=8 bits |
| cmdCode | output | 4 | Command code from the command byte |
| byteOut | output | 8 | Last completed data byte |
| byteValid | output | 1 | One-cycle strobe for a new `byteOut` |

## Verification
If the beat counter goes off by one, or misses its reset on deselect, the fault shows as a byte strobe one or more edges early or late. It also shows as a rotated or corrupted `byteOut` on the first byte of the frame, and so is seen within 8 edges. A wrong width or command register shows at the `busWidth` and `cmdCode` outputs one cycle after the command edge. If either register is disturbed in the data phase, the change shows at every byte strobe, and every later byte of that frame has the wrong length. The bench sweeps all 256 command bytes, sends two data bytes at each decoded width with noise on the unused lines, and aborts frames part-way through a byte.

// File: rtl/cwsPkg.sv
package cwsPkg;
  localparam int BUS_W = 8;
  localparam int CMD_W = 4;
  localparam int CNT_W = $clog2(BUS_W);

  // flag and command line positions: the master's encoding depends on these
  localparam int FLAG2_POS = 1;
  localparam int FLAG4_POS = 2;
  localparam int FLAG8_POS = 4;

  typedef enum logic [1:0] {WID1 = 2'd0, WID2 = 2'd1, WID4 = 2'd2, WID8 = 2'd3} widthT;

  typedef struct packed {
    logic capture;
    logic shift;
    logic finish;
    logic abort;
  } strobeT;

  function automatic widthT decodeWidth(input logic [BUS_W-1:0] b);
    if (!b[FLAG8_POS])      return WID8;
    else if (!b[FLAG4_POS]) return WID4;
    else if (!b[FLAG2_POS]) return WID2;
    else                    return WID1;
  endfunction

  function automatic logic [CMD_W-1:0] extractCmd(input logic [BUS_W-1:0] b);
    return {b[0], b[3], b[5], b[6]};
  endfunction

  // index of the final beat of a byte for each width
  function automatic logic [CNT_W-1:0] lastBeat(input widthT w);
    case (w)
      WID1:    return CNT_W'(BUS_W - 1);
      WID2:    return CNT_W'(BUS_W / 2 - 1);
      WID4:    return CNT_W'(BUS_W / 4 - 1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cwsControl.sv
module cwsControl
  import cwsPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   selN,
  input  widthT  width,
  output strobeT strobes,
  output logic   active
);
  logic activeReg;
  logic [CNT_W-1:0] beatCnt;

  always_comb begin
    strobes.abort   = selN;
    strobes.capture = !selN && !activeReg;
    strobes.shift   = !selN && activeReg;
    strobes.finish  = strobes.shift && (beatCnt == lastBeat(width));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeReg <= 1'b0;   // R1
      beatCnt   <= '0;
    end else if (strobes.abort) begin
      activeReg <= 1'b0;   // R8
      beatCnt   <= '0;
    end else if (strobes.capture) begin
      activeReg <= 1'b1;
      beatCnt   <= '0;
    end else if (strobes.finish) begin
      beatCnt   <= '0;
    end else if (strobes.shift) begin
      beatCnt   <= beatCnt + 1'b1;
    end
  end

  assign active = activeReg;

  assert_capture_opens_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !active) |=> active);
  assert_deselect_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    selN |=> (!active && beatCnt == '0));
  assert_beat_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (beatCnt <= lastBeat(width)));
endmodule

// File: rtl/cwsDatapath.sv
module cwsDatapath
  import cwsPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] dataIn,
  input  strobeT           strobes,
  output widthT            width,
  output logic [CMD_W-1:0] cmd,
  output logic [BUS_W-1:0] byteOut,
  output logic             byteValid
);
  widthT            widthReg;
  logic [CMD_W-1:0] cmdReg;
  logic [BUS_W-1:0] shiftReg;
  logic [BUS_W-1:0] nextShift;

  // new bits enter at the top so the first chunk ends in the low bits
  always_comb begin
    case (widthReg)
      WID1:    nextShift = {dataIn[0],   shiftReg[BUS_W-1:1]};
      WID2:    nextShift = {dataIn[1:0], shiftReg[BUS_W-1:2]};
      WID4:    nextShift = {dataIn[3:0], shiftReg[BUS_W-1:4]};
      default: nextShift = dataIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthReg  <= WID1;
      cmdReg    <= '0;
      shiftReg  <= '0;
      byteOut   <= '0;
      byteValid <= 1'b0;   // R1
    end else begin
      byteValid <= 1'b0;
      if (strobes.capture) begin
        widthReg <= decodeWidth(dataIn);
        cmdReg   <= extractCmd(dataIn);
        shiftReg <= '0;
      end else if (strobes.shift) begin
        shiftReg <= nextShift;
        if (strobes.finish) begin
          byteOut   <= nextShift;
          byteValid <= 1'b1;
        end
      end
    end
  end

  assign width = widthReg;
  assign cmd   = cmdReg;

  assert_flag8_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !dataIn[FLAG8_POS]) |=> (widthReg == WID8));
  assert_hold_in_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(widthReg) && $stable(cmdReg)));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && widthReg != WID8) |=> !byteValid);
  assert_abort_no_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.abort |=> !byteValid);
endmodule

// File: rtl/cmdWidthSlave.sv
module cmdWidthSlave
  import cwsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic [7:0] dataIn,
  output logic       active,
  output logic [1:0] busWidth,
  output logic [3:0] cmdCode,
  output logic [7:0] byteOut,
  output logic       byteValid
);
  strobeT strobes;
  widthT  width;

  cwsControl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .selN    (selN),
    .width   (width),
    .strobes (strobes),
    .active  (active)
  );

  cwsDatapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .strobes   (strobes),
    .width     (width),
    .cmd       (cmdCode),
    .byteOut   (byteOut),
    .byteValid (byteValid)
  );

  assign busWidth = width;
endmodule

// File: tb/sim_cmdWidthSlave.sv
`timescale 1ns/1ps
module sim_cmdWidthSlave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1;
  logic [7:0] dataIn = 8'hFF;
  logic active, byteValid;
  logic [1:0] busWidth;
  logic [3:0] cmdCode;
  logic [7:0] byteOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cmdWidthSlave u0 (
    .clk(clk), .rstN(rstN), .selN(selN), .dataIn(dataIn),
    .active(active), .busWidth(busWidth), .cmdCode(cmdCode),
    .byteOut(byteOut), .byteValid(byteValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expWidthCode(input logic [7:0] b);
    if (!b[4]) return 3;
    if (!b[2]) return 2;
    if (!b[1]) return 1;
    return 0;
  endfunction

  function automatic int expCmd(input logic [7:0] b);
    return {b[0], b[3], b[5], b[6]};
  endfunction

  // open a frame and check the command edge
  task automatic openFrame(input logic [7:0] cb);
    selN = 1'b0;
    dataIn = cb;
    @(negedge clk);
    chk("R2 active", int'(active), 1);
    chk(cb == 8'hFF ? "R4 width" : "R3 width", int'(busWidth), expWidthCode(cb));
    chk("R2 cmd", int'(cmdCode), expCmd(cb));
  endtask

  task automatic closeFrame();
    selN = 1'b1;
    dataIn = 8'hFF;
    @(negedge clk);
    chk("R8 active", int'(active), 0);
    chk("R8 valid", int'(byteValid), 0);
  endtask

  task automatic runXfer(input logic [7:0] cb, input int nBytes, input int seed);
    int w, beats, mask, wc;
    openFrame(cb);
    wc = expWidthCode(cb);
    w = 1 << wc;
    beats = 8 / w;
    mask = (1 << w) - 1;
    for (int i = 0; i < nBytes; i++) begin
      int val = (seed + i * 37) & 8'hFF;
      int noise = (val ^ 8'h5A ^ cb) & 8'hFF;
      for (int k = 0; k < beats; k++) begin
        dataIn = 8'(((val >> (k * w)) & mask) | (noise & ~mask));
        @(negedge clk);
        if (k == beats - 1) begin
          chk("R6 valid", int'(byteValid), 1);
          chk("R5,R7 byte", int'(byteOut), val);
          chk("R9 width", int'(busWidth), wc);
          chk("R9 cmd", int'(cmdCode), expCmd(cb));
        end else begin
          chk("R6 idle", int'(byteValid), 0);
        end
      end
    end
    closeFrame();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 active", int'(active), 0);
    chk("R1 valid", int'(byteValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 active after", int'(active), 0);

    // full sweep of command bytes, two data bytes each
    for (int cb = 0; cb < 256; cb++) runXfer(8'(cb), 2, cb * 11 + 3);

    // R4: all lines high gives 1-bit width
    runXfer(8'hFF, 3, 8'h96);

    // R8: abort mid-byte at 1-bit width, then a clean frame
    openFrame(8'hFF);
    for (int k = 0; k < 3; k++) begin
      dataIn = 8'hFF;
      @(negedge clk);
      chk("R8 no early valid", int'(byteValid), 0);
    end
    closeFrame();
    runXfer(8'hFF, 1, 8'h3C);

    // R8: abort mid-byte at 2-bit width, then same width again
    openFrame(8'hFD);
    dataIn = 8'hFF;
    @(negedge clk);
    closeFrame();
    runXfer(8'hFD, 1, 8'hC1);

    // R8: back-to-back frames with different widths
    runXfer(8'hEF, 2, 8'h01);
    runXfer(8'hFB, 2, 8'h80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule